// File: doc/BRIEF.md
# Mixed Decay Chopper Sequencer

This block sequences the four gate controls of one H-bridge so that a motor winding is held near a current threshold. It runs from the chopping oscillator clock and divides time into periods of a fixed number of clocks. Each period opens with the bridge driving current into the winding. A digital comparator input reports that the sensed current has reached the threshold. The bridge then recirculates the current through both low-side switches. From a fixed point in the period, it instead returns the current to the supply through the opposite diagonal. A polarity input selects which diagonal counts as driving.

The sequencer has four states: OFF (all gates open), CHARGE, SLOW and FAST. Its transitions are named as follows.
- Start: OFF to CHARGE when enable is high.
- Detect: CHARGE to SLOW, or to FAST when the detect comes too late for slow decay.
- Switchover: SLOW to FAST at the mixed decay point.
- Wrap: any active state to CHARGE at the end of a period.
- Restart: any active state to CHARGE when the step strobe is high.
- Drop: any state to OFF when enable is low.

The comparator is blanked for the first clocks of each period, which hides switching noise. Because every period opens with CHARGE, a threshold that has just been lowered is still compared. A step strobe, raised when the threshold changes, opens a fresh period at once.

Top module: `chop_mixed_decay`

## Requirements
- R1: A period lasts PERIOD_CLKS clocks (default 16). Positions count 0 to 15, and the clock after position 15 is position 0 of the next period.
- R2: Position 0 of every period is in CHARGE, whatever state the previous period ended in.
- R3: The comparator is ignored while the position is below BLANK_CLKS (default 2). A comparator pulse confined to those positions leaves the bridge in CHARGE for the whole period.
- R4: If the comparator is seen at position d, with d below MDT_CLK-1 (MDT_CLK default 6), the positions after d up to MDT_CLK-1 are SLOW. Positions MDT_CLK to 15 are FAST.
- R5: If the comparator is first seen at a position d of MDT_CLK-1 or later, the positions after d are FAST until the period ends. With no detect, the whole period stays in CHARGE.
- R6: With polarity high, the gates {u1,l1,u2,l2} are 1001 in CHARGE, 0101 in SLOW and 0110 in FAST.
- R7: With polarity low, the gates {u1,l1,u2,l2} are 0110 in CHARGE, 0101 in SLOW and 1001 in FAST.
- R8: One clock after enable is sampled low, all four gates are 0. After enable rises, the next clock is position 0 in CHARGE.
- R9: A step strobe sampled high while enabled makes the next clock position 0 of a new period in CHARGE. The strobe wins over a comparator detect sampled on the same edge.
- R10: u1 and l1 are never both 1, and u2 and l2 are never both 1.
- R11: During and right after reset, all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chopping oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output stage enable |
| cmp_hit | input | 1 | Sensed current has reached the threshold |
| cur_pos | input | 1 | Current polarity: 1 positive, 0 negative |
| step_new | input | 1 | New threshold strobe, restarts the period |
| u1 | output | 1 | Leg 1 high-side gate |
| l1 | output | 1 | Leg 1 low-side gate |
| u2 | output | 1 | Leg 2 high-side gate |
| l2 | output | 1 | Leg 2 low-side gate |

## Verification
Two functions can fall on the same edge. The first pair is the step strobe and a comparator detect. The bench holds both high on the edge where the position is past blanking. It then expects CHARGE at position 0, not SLOW, and walks the following full period against the expected phases. The second pair is the end-of-period wrap and a late detect. A comparator first raised at position 15 must give CHARGE at the next position 0, not FAST.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_CHARGE = 2'd1,
        PH_SLOW   = 2'd2,
        PH_FAST   = 2'd3
    } phase_e;

    typedef struct packed {
        logic u1;
        logic l1;
        logic u2;
        logic l2;
    } gates_t;

endpackage

// File: rtl/chop_period_cnt.sv
module chop_period_cnt #(
    parameter int PERIOD_CLKS = 16,
    localparam int CW = $clog2(PERIOD_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] pos,
    output logic          last
);
    localparam logic [CW-1:0] LAST_POS = CW'(PERIOD_CLKS - 1);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clr) begin
            pos_q <= '0;
        end else if (inc) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    assign pos  = pos_q;
    assign last = (pos_q == LAST_POS);

    // R1: the position wraps to zero after the last clock of a period
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && pos_q == LAST_POS) |=> (pos_q == '0));

    // R1: inside a period the position advances by one each clock
    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && pos_q != LAST_POS) |=> (pos_q == CW'($past(pos_q) + 1'b1)));

endmodule

// File: rtl/chop_blank.sv
module chop_blank #(
    parameter int BLANK_CLKS = 2,
    localparam int BW = $clog2(BLANK_CLKS + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic blanked
);
    generate
        if (BLANK_CLKS == 0) begin : g_noblank
            assign blanked = 1'b0;
        end else begin : g_blank
            localparam logic [BW-1:0] BLIM = BW'(BLANK_CLKS);
            logic [BW-1:0] age_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q <= '0;
                end else if (restart) begin
                    age_q <= '0;
                end else if (age_q != BLIM) begin
                    age_q <= age_q + 1'b1;
                end
            end

            assign blanked = (age_q < BLIM);

            // R3: a fresh period always opens inside the blanking window
            p_blank_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> blanked);
        end
    endgenerate

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  phase_e ph,
    input  logic   pos_dir,
    output gates_t gates
);
    always_comb begin
        gates = '0;
        unique case (ph)
            PH_OFF:    gates = '0;
            PH_CHARGE: gates = pos_dir ? 4'b1001 : 4'b0110;
            PH_SLOW:   gates = 4'b0101;
            PH_FAST:   gates = pos_dir ? 4'b0110 : 4'b1001;
        endcase
    end

    // R10: no leg ever has both switches closed
    always_comb begin
        a_leg1_r10: assert (!(gates.u1 && gates.l1));
        a_leg2_r10: assert (!(gates.u2 && gates.l2));
    end

endmodule

// File: rtl/chop_mixed_decay.sv
module chop_mixed_decay
    import chop_pkg::*;
#(
    parameter int PERIOD_CLKS = 16,
    parameter int MDT_CLK     = 6,
    parameter int BLANK_CLKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_hit,
    input  logic cur_pos,
    input  logic step_new,
    output logic u1,
    output logic l1,
    output logic u2,
    output logic l2
);
    localparam int CW = $clog2(PERIOD_CLKS);
    localparam logic [CW-1:0] MDT_PRE = CW'(MDT_CLK - 1);

    phase_e        state_q;
    phase_e        state_d;
    logic [CW-1:0] pos;
    logic          last;
    logic          blanked;
    logic          start_per;
    logic          detect;
    gates_t        gates;

    assign start_per = en && ((state_q == PH_OFF) || last || step_new);
    assign detect    = cmp_hit && !blanked;

    chop_period_cnt #(.PERIOD_CLKS(PERIOD_CLKS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en || start_per),
        .inc   (state_q != PH_OFF),
        .pos   (pos),
        .last  (last)
    );

    chop_blank #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_per),
        .blanked (blanked)
    );

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = PH_OFF;
        end else if (start_per) begin
            state_d = PH_CHARGE;
        end else begin
            unique case (state_q)
                PH_OFF:    state_d = PH_OFF;
                PH_CHARGE: if (detect) state_d = (pos < MDT_PRE) ? PH_SLOW : PH_FAST;
                PH_SLOW:   if (pos == MDT_PRE) state_d = PH_FAST;
                PH_FAST:   state_d = PH_FAST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_OFF;
        else        state_q <= state_d;
    end

    chop_gate_map u_map (
        .ph      (state_q),
        .pos_dir (cur_pos),
        .gates   (gates)
    );

    assign u1 = gates.u1;
    assign l1 = gates.l1;
    assign u2 = gates.u2;
    assign l2 = gates.l2;

    // R8: a low enable opens every gate one clock later
    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!u1 && !l1 && !u2 && !l2));

    // R9: a step strobe restarts the period in CHARGE
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step_new) |=> (state_q == PH_CHARGE && pos == '0));

    // R3: a blanked comparator cannot end CHARGE
    p_blank_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start_per && state_q == PH_CHARGE && blanked) |=> (state_q == PH_CHARGE));

    // R4: slow decay hands over to fast decay at the mixed decay point
    p_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start_per && state_q == PH_SLOW && pos == MDT_PRE) |=> (state_q == PH_FAST));

    // R2: position zero of any period is CHARGE
    p_open_charge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_OFF && pos == '0) |-> (state_q == PH_CHARGE));

endmodule

// File: tb/test_chop_mixed_decay.sv
`timescale 1ns/1ps
module test_chop_mixed_decay;
    localparam int BLANK = 2;
    localparam int MDT   = 6;
    localparam int NEVER = 99;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cmp_hit = 1'b0;
    logic cur_pos = 1'b1;
    logic step_new = 1'b0;
    logic u1, l1, u2, l2;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    chop_mixed_decay i_chop_mixed_decay (
        .clk(clk), .rst_n(rst_n), .en(en), .cmp_hit(cmp_hit),
        .cur_pos(cur_pos), .step_new(step_new),
        .u1(u1), .l1(l1), .u2(u2), .l2(l2)
    );

    function automatic logic [3:0] exp_g(int p, int c, int ce, bit pol);
        int d;
        d = (c < BLANK) ? BLANK : c;
        if (d > ce || d > 15) return pol ? 4'b1001 : 4'b0110;
        if (p <= d)           return pol ? 4'b1001 : 4'b0110;
        if (p < MDT)          return 4'b0101;
        return pol ? 4'b0110 : 4'b1001;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gates actual %b expected %b at %0t", req, act, exp, $time);
        end
        checks++;
        if ((act[3] && act[2]) || (act[1] && act[0])) begin
            errors++;
            $display("FAIL R10: leg overlap actual %b expected no overlap", act);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // walk positions from..to, comparing each, driving cmp for window [c,ce]
    task automatic walk(string req, int c, int ce, int from, int to);
        for (int p = from; p <= to; p++) begin
            check(req, {u1, l1, u2, l2}, exp_g(p, c, ce, cur_pos));
            cmp_hit = (p >= c && p <= ce);
            if (p < to) tick();
        end
    endtask

    task automatic start();
        en = 1'b1;
        tick();
    endtask

    task automatic stop();
        en = 1'b0;
        cmp_hit = 1'b0;
        tick();
        tick();
    endtask

    task automatic t_reset();
        #1;
        check("R11", {u1, l1, u2, l2}, 4'b0000);
        tick();
        rst_n = 1'b1;
        tick();
        check("R11", {u1, l1, u2, l2}, 4'b0000);
    endtask

    task automatic t_disabled();
        for (int i = 0; i < 4; i++) begin
            cmp_hit = i[0];
            tick();
            check("R8 idle", {u1, l1, u2, l2}, 4'b0000);
        end
        cmp_hit = 1'b0;
    endtask

    task automatic t_early_detect();
        cur_pos = 1'b1;
        start();
        walk("R4 R6 early", 0, NEVER, 0, 15);
        tick();
        walk("R1 R2 wrap", 0, NEVER, 0, 7);
        stop();
    endtask

    task automatic t_late_detect();
        start();
        walk("R5 late", 8, NEVER, 0, 15);
        tick();
        walk("R2 forced charge", 8, NEVER, 0, 3);
        stop();
        start();
        walk("R5 at mdt-1", 5, NEVER, 0, 15);
        stop();
        start();
        walk("R5 at 15", 15, NEVER, 0, 15);
        tick();
        check("R1 R2 wrap beats late detect", {u1, l1, u2, l2}, 4'b1001);
        stop();
    endtask

    task automatic t_no_detect();
        start();
        walk("R5 none", NEVER, NEVER, 0, 15);
        tick();
        walk("R1 none", NEVER, NEVER, 0, 2);
        stop();
    endtask

    task automatic t_negative();
        cur_pos = 1'b0;
        start();
        walk("R7 neg", 3, NEVER, 0, 15);
        stop();
        cur_pos = 1'b1;
    endtask

    task automatic t_blanking();
        start();
        walk("R3 blank pulse", 0, 1, 0, 15);
        stop();
        start();
        walk("R3 edge", 2, 2, 0, 15);
        stop();
    endtask

    task automatic t_step();
        start();
        walk("R9 before", 2, NEVER, 0, 10);
        step_new = 1'b1;
        tick();
        step_new = 1'b0;
        walk("R9 after step", 2, NEVER, 0, 15);
        stop();
    endtask

    task automatic t_step_vs_detect();
        start();
        walk("R9 lead", 4, NEVER, 0, 4);
        step_new = 1'b1;
        tick();
        step_new = 1'b0;
        check("R9 strobe beats detect", {u1, l1, u2, l2}, 4'b1001);
        walk("R9 next period", 4, NEVER, 0, 15);
        stop();
    endtask

    task automatic t_enable_drop();
        start();
        walk("R8 pre", 2, NEVER, 0, 8);
        en = 1'b0;
        tick();
        check("R8 drop", {u1, l1, u2, l2}, 4'b0000);
        cmp_hit = 1'b0;
        tick();
        check("R8 held", {u1, l1, u2, l2}, 4'b0000);
        en = 1'b1;
        tick();
        walk("R8 restart", 2, NEVER, 0, 15);
        stop();
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_early_detect();
        t_late_detect();
        t_no_detect();
        t_negative();
        t_blanking();
        t_step();
        t_step_vs_detect();
        t_enable_drop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule